// File: doc/BRIEF.md
# Shared-Bus Channel Configuration Latch Bank

This block keeps the per-channel control settings of a four-channel serial transceiver. One 8-bit configuration bus is shared by three holding latches. Each latch has its own load strobe. The first latch drives the serial output-driver enables, the second selects self-test or normal operation for every transmit and receive channel, and the third controls the power enables of the receive channels.

While a strobe is high, its latch is open and copies the bus once per clock. When the strobe drops, the latch keeps the last bus value it copied. The strobes, the bus and the active-low reset are all first brought into the system clock domain through synchronizer chains. A sampled reset puts every latch into its safe state. The one exception is the self-test latch: it is cleared only while its own strobe is low.

Top module: `cfgLatchBank`

## Requirements
- R1: While drvStrobe is high and reset is inactive, drvEn[k] follows bus bit 2k (1 means the driver is on). A steady input reaches the outputs after three clock edges: two synchronizer stages and one latch stage.
- R2: After a strobe goes low, its latch holds its value. Bus changes have no effect, including a change that arrives in the same cycle as the falling strobe.
- R3: While testStrobe is high, txNormal[k] follows bus bit 2k and rxNormal[k] follows bus bit 2k+1. In both, a value of 0 selects the self-test pattern mode and a value of 1 selects normal operation.
- R4: While pwrStrobe is high and reset is inactive, rxPwrEn[k] follows bus bit 2k+1. A value of 1 keeps receiver k active and 0 powers it down.
- R5: A latch whose strobe is low is not affected by bus activity under the other strobes. When several strobes are high together, each latch loads the same bus value.
- R6: A sampled low rstN forces drvEn to all zeros, even while drvStrobe is high.
- R7: A sampled low rstN forces rxPwrEn to all zeros, even while pwrStrobe is high.
- R8: A sampled low rstN while testStrobe is low forces txNormal and rxNormal to all ones.
- R9: While testStrobe is high, a sampled low rstN does not clear the self-test latch, and the latch keeps following the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset, sampled through a synchronizer |
| cfgBus | input | 8 | Shared configuration bus; bit 2k is transmit side, bit 2k+1 is receive side of channel k |
| drvStrobe | input | 1 | Load strobe of the output-driver latch |
| testStrobe | input | 1 | Load strobe of the self-test select latch |
| pwrStrobe | input | 1 | Load strobe of the receive-power latch |
| drvEn | output | 4 | Serial output-driver enables, 1 = on |
| txNormal | output | 4 | Transmit mode per channel, 0 = self-test, 1 = normal |
| rxNormal | output | 4 | Receive mode per channel, 0 = self-test, 1 = normal |
| rxPwrEn | output | 4 | Receive power enables, 1 = active |

## Verification
The assertions check the per-cycle behaviour after synchronization. An open latch must copy the synchronized bus on the next edge. A closed latch must stay stable. The driver and power latches must clear on any sampled reset, and the self-test latch must return to normal mode under a reset taken while it is closed. Other behaviours can be shown only by the bench scenarios, because they need several steps in a row:
- the three-cycle input-to-output latency;
- a bus change that coincides with a falling strobe and must be ignored;
- the inverted polarity of the self-test field;
- reset applied with the self-test strobe high compared with reset applied with it low.

// File: rtl/cfgLatchPkg.sv
package cfgLatchPkg;
  typedef struct packed {
    logic loadDrv;
    logic loadTest;
    logic loadPwr;
    logic clrDrv;
    logic clrTest;
    logic clrPwr;
  } latchCtl_t;
endpackage

// File: rtl/cfgSync.sv
module cfgSync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk) stage[0] <= d;

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) stage[i] <= stage[i-1];
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/cfgLatchCtl.sv
module cfgLatchCtl
  import cfgLatchPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      drvStrobe,
  input  logic      testStrobe,
  input  logic      pwrStrobe,
  output latchCtl_t ctl
);
  logic [3:0] syncIn;
  logic [3:0] syncOut;
  logic       rstActive;
  logic       drvOpen;
  logic       testOpen;
  logic       pwrOpen;

  assign syncIn = {rstN, drvStrobe, testStrobe, pwrStrobe};

  cfgSync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_ctlSync (
    .clk (clk),
    .d   (syncIn),
    .q   (syncOut)
  );

  assign rstActive = ~syncOut[3];
  assign drvOpen   = syncOut[2];
  assign testOpen  = syncOut[1];
  assign pwrOpen   = syncOut[0];

  always_comb begin
    ctl          = '0;
    // reset wins over an open strobe for driver and power latches
    ctl.clrDrv   = rstActive;
    ctl.loadDrv  = drvOpen & ~rstActive;
    ctl.clrPwr   = rstActive;
    ctl.loadPwr  = pwrOpen & ~rstActive;
    // self-test latch: reset only acts while the latch is closed
    ctl.loadTest = testOpen;
    ctl.clrTest  = rstActive & ~testOpen;
  end
endmodule

// File: rtl/cfgLatchDp.sv
module cfgLatchDp
  import cfgLatchPkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int SYNC_STAGES = 2,
  localparam int BUS_W      = 2 * NUM_CH
) (
  input  logic              clk,
  input  logic [BUS_W-1:0]  cfgBus,
  input  latchCtl_t         ctl,
  output logic [BUS_W-1:0]  busSync,
  output logic [NUM_CH-1:0] drvEn,
  output logic [NUM_CH-1:0] txNormal,
  output logic [NUM_CH-1:0] rxNormal,
  output logic [NUM_CH-1:0] rxPwrEn
);
  logic [NUM_CH-1:0] txSide;
  logic [NUM_CH-1:0] rxSide;

  cfgSync #(.WIDTH(BUS_W), .STAGES(SYNC_STAGES)) u_busSync (
    .clk (clk),
    .d   (cfgBus),
    .q   (busSync)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_split
    assign txSide[ch] = busSync[2*ch];
    assign rxSide[ch] = busSync[2*ch+1];
  end

  always_ff @(posedge clk) begin
    if (ctl.clrDrv)       drvEn <= '0;
    else if (ctl.loadDrv) drvEn <= txSide;
  end

  always_ff @(posedge clk) begin
    if (ctl.clrTest) begin
      txNormal <= '1;
      rxNormal <= '1;
    end else if (ctl.loadTest) begin
      txNormal <= txSide;
      rxNormal <= rxSide;
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.clrPwr)       rxPwrEn <= '0;
    else if (ctl.loadPwr) rxPwrEn <= rxSide;
  end
endmodule

// File: rtl/cfgLatchBank.sv
module cfgLatchBank
  import cfgLatchPkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int SYNC_STAGES = 2,
  localparam int BUS_W      = 2 * NUM_CH
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BUS_W-1:0]  cfgBus,
  input  logic              drvStrobe,
  input  logic              testStrobe,
  input  logic              pwrStrobe,
  output logic [NUM_CH-1:0] drvEn,
  output logic [NUM_CH-1:0] txNormal,
  output logic [NUM_CH-1:0] rxNormal,
  output logic [NUM_CH-1:0] rxPwrEn
);
  latchCtl_t        ctlBus;
  logic [BUS_W-1:0] busSync;

  cfgLatchCtl #(.SYNC_STAGES(SYNC_STAGES)) u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .drvStrobe  (drvStrobe),
    .testStrobe (testStrobe),
    .pwrStrobe  (pwrStrobe),
    .ctl        (ctlBus)
  );

  cfgLatchDp #(.NUM_CH(NUM_CH), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk      (clk),
    .cfgBus   (cfgBus),
    .ctl      (ctlBus),
    .busSync  (busSync),
    .drvEn    (drvEn),
    .txNormal (txNormal),
    .rxNormal (rxNormal),
    .rxPwrEn  (rxPwrEn)
  );
endmodule

// File: rtl/cfgLatchChk.sv
module cfgLatchChk
  import cfgLatchPkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int BUS_W = 2 * NUM_CH
) (
  input logic              clk,
  input latchCtl_t         ctl,
  input logic [BUS_W-1:0]  busSync,
  input logic [NUM_CH-1:0] drvEn,
  input logic [NUM_CH-1:0] txNormal,
  input logic [NUM_CH-1:0] rxNormal,
  input logic [NUM_CH-1:0] rxPwrEn
);
  logic              primed = 1'b0;
  logic [NUM_CH-1:0] busEven;
  logic [NUM_CH-1:0] busOdd;

  always_ff @(posedge clk) primed <= 1'b1;

  always_comb begin
    for (int k = 0; k < NUM_CH; k++) begin
      busEven[k] = busSync[2*k];
      busOdd[k]  = busSync[2*k+1];
    end
  end

  AST_DRV_FOLLOW: assert property (@(posedge clk) disable iff (!primed) ctl.loadDrv |=> drvEn == $past(busEven)); // R1
  AST_DRV_HELD: assert property (@(posedge clk) disable iff (!primed) (!ctl.loadDrv && !ctl.clrDrv) |=> $stable(drvEn)); // R2
  AST_TEST_HELD: assert property (@(posedge clk) disable iff (!primed) (!ctl.loadTest && !ctl.clrTest) |=> ($stable(txNormal) && $stable(rxNormal))); // R2
  AST_TEST_FOLLOW: assert property (@(posedge clk) disable iff (!primed) ctl.loadTest |=> (txNormal == $past(busEven) && rxNormal == $past(busOdd))); // R3
  AST_PWR_FOLLOW: assert property (@(posedge clk) disable iff (!primed) ctl.loadPwr |=> rxPwrEn == $past(busOdd)); // R4
  AST_PWR_HELD: assert property (@(posedge clk) disable iff (!primed) (!ctl.loadPwr && !ctl.clrPwr) |=> $stable(rxPwrEn)); // R5
  AST_DRV_CLEARED: assert property (@(posedge clk) disable iff (!primed) ctl.clrDrv |=> drvEn == '0); // R6
  AST_PWR_CLEARED: assert property (@(posedge clk) disable iff (!primed) ctl.clrPwr |=> rxPwrEn == '0); // R7
  AST_TEST_SAFE: assert property (@(posedge clk) disable iff (!primed) ctl.clrTest |=> (&txNormal && &rxNormal)); // R8
  AST_TEST_NO_CLEAR_OPEN: assert property (@(posedge clk) disable iff (!primed) (ctl.clrDrv && ctl.loadTest) |=> txNormal == $past(busEven)); // R9
endmodule

bind cfgLatchBank cfgLatchChk #(.NUM_CH(NUM_CH)) u_chk (
  .clk      (clk),
  .ctl      (ctlBus),
  .busSync  (busSync),
  .drvEn    (drvEn),
  .txNormal (txNormal),
  .rxNormal (rxNormal),
  .rxPwrEn  (rxPwrEn)
);

// File: tb/test_cfgLatchBank.sv
module test_cfgLatchBank;
  localparam int NUM_CH = 4;
  localparam int BUS_W  = 2 * NUM_CH;

  typedef struct {
    string            tag;
    logic [NUM_CH-1:0] drv;
    logic [NUM_CH-1:0] tx;
    logic [NUM_CH-1:0] rx;
    logic [NUM_CH-1:0] pwr;
  } expItem_t;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [BUS_W-1:0]  cfgBus = '0;
  logic              drvStrobe = 1'b0;
  logic              testStrobe = 1'b0;
  logic              pwrStrobe = 1'b0;
  logic [NUM_CH-1:0] drvEn;
  logic [NUM_CH-1:0] txNormal;
  logic [NUM_CH-1:0] rxNormal;
  logic [NUM_CH-1:0] rxPwrEn;

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 1'b0;
  expItem_t scoreQ[$];

  logic [NUM_CH-1:0] mDrv = '0;
  logic [NUM_CH-1:0] mTx  = '1;
  logic [NUM_CH-1:0] mRx  = '1;
  logic [NUM_CH-1:0] mPwr = '0;

  always #10 clk = ~clk;

  cfgLatchBank #(.NUM_CH(NUM_CH)) i_cfgLatchBank (
    .clk        (clk),
    .rstN       (rstN),
    .cfgBus     (cfgBus),
    .drvStrobe  (drvStrobe),
    .testStrobe (testStrobe),
    .pwrStrobe  (pwrStrobe),
    .drvEn      (drvEn),
    .txNormal   (txNormal),
    .rxNormal   (rxNormal),
    .rxPwrEn    (rxPwrEn)
  );

  function automatic logic [NUM_CH-1:0] evenOf(logic [BUS_W-1:0] b);
    logic [NUM_CH-1:0] r;
    for (int k = 0; k < NUM_CH; k++) r[k] = b[2*k];
    return r;
  endfunction

  function automatic logic [NUM_CH-1:0] oddOf(logic [BUS_W-1:0] b);
    logic [NUM_CH-1:0] r;
    for (int k = 0; k < NUM_CH; k++) r[k] = b[2*k+1];
    return r;
  endfunction

  // drive inputs, let them settle through sync + latch, push expected state
  task automatic step(string tag, logic [BUS_W-1:0] bus, logic d, logic t, logic p, logic rn);
    expItem_t it;
    @(negedge clk);
    cfgBus = bus; drvStrobe = d; testStrobe = t; pwrStrobe = p; rstN = rn;
    if (!rn) begin
      mDrv = '0;
      mPwr = '0;
      if (t) begin mTx = evenOf(bus); mRx = oddOf(bus); end
      else   begin mTx = '1;          mRx = '1;         end
    end else begin
      if (d) mDrv = evenOf(bus);
      if (t) begin mTx = evenOf(bus); mRx = oddOf(bus); end
      if (p) mPwr = oddOf(bus);
    end
    repeat (4) @(posedge clk);
    it.tag = tag; it.drv = mDrv; it.tx = mTx; it.rx = mRx; it.pwr = mPwr;
    scoreQ.push_back(it);
    @(negedge clk);
  endtask

  // monitor: compares queued expectations at falling edges
  initial begin
    forever begin
      @(negedge clk);
      while (scoreQ.size() > 0) begin
        expItem_t e;
        e = scoreQ.pop_front();
        checkCount++;
        if (drvEn !== e.drv || txNormal !== e.tx || rxNormal !== e.rx || rxPwrEn !== e.pwr) begin
          failCount++;
          $display("FAIL %s: got drv=%b tx=%b rx=%b pwr=%b, expected drv=%b tx=%b rx=%b pwr=%b",
                   e.tag, drvEn, txNormal, rxNormal, rxPwrEn, e.drv, e.tx, e.rx, e.pwr);
        end
      end
    end
  end

  // latency check: output must not move before the third edge
  task automatic latencyCheck();
    @(negedge clk);
    cfgBus = 8'h55; drvStrobe = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    checkCount++;
    if (drvEn !== 4'b0000) begin
      failCount++;
      $display("FAIL R1 latency early: got %b expected %b", drvEn, 4'b0000);
    end
    @(posedge clk);
    @(negedge clk);
    checkCount++;
    if (drvEn !== 4'b1111) begin
      failCount++;
      $display("FAIL R1 latency third edge: got %b expected %b", drvEn, 4'b1111);
    end
    mDrv = 4'b1111;
    step("R1 hold open", 8'h55, 1'b1, 1'b0, 1'b0, 1'b1);
  endtask

  initial begin
    step("R6 R7 R8 reset state", 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    step("R6 reset released", 8'h00, 1'b0, 1'b0, 1'b0, 1'b1);
    latencyCheck();
    step("R1 driver load A5", 8'hA5, 1'b1, 1'b0, 1'b0, 1'b1);
    step("R1 driver follows 3C", 8'h3C, 1'b1, 1'b0, 1'b0, 1'b1);
    step("R2 bus change with strobe fall", 8'hFF, 1'b0, 1'b0, 1'b0, 1'b1);
    step("R2 R5 later bus change", 8'h81, 1'b0, 1'b0, 1'b0, 1'b1);
    step("R3 self-test select 96", 8'h96, 1'b0, 1'b1, 1'b0, 1'b1);
    step("R3 all self-test 00", 8'h00, 1'b0, 1'b1, 1'b0, 1'b1);
    step("R2 test latch closed", 8'hFF, 1'b0, 1'b0, 1'b0, 1'b1);
    step("R4 power load AA", 8'hAA, 1'b0, 1'b0, 1'b1, 1'b1);
    step("R4 power load 62", 8'h62, 1'b0, 1'b0, 1'b1, 1'b1);
    step("R2 power held", 8'h00, 1'b0, 1'b0, 1'b0, 1'b1);
    step("R5 all strobes 5A", 8'h5A, 1'b1, 1'b1, 1'b1, 1'b1);
    step("R5 all closed", 8'hC3, 1'b0, 1'b0, 1'b0, 1'b1);
    step("R8 reset test strobe low", 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    step("R6 R7 reset beats open strobes", 8'hFF, 1'b1, 1'b0, 1'b1, 1'b0);
    step("R9 reset test strobe high 00", 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
    step("R9 follows bus in reset 0F", 8'h0F, 1'b0, 1'b1, 1'b0, 1'b0);
    step("R8 strobe drops in reset", 8'h0F, 1'b0, 1'b0, 1'b0, 1'b0);
    step("R1 after reset", 8'h44, 1'b1, 1'b0, 1'b1, 1'b1);
    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end
endmodule